// File: doc/BRIEF.md
# First-Eight-Hits Sparse Collector

The collector turns a wide, mostly empty strip readout into a short list. It takes a record for each of 128 strips once per readout period: a hit flag and a 6-bit payload. It keeps only the lowest-numbered strips that fired, up to eight of them. Each kept strip lands on its own 13-bit output slot, which carries the strip index and that strip's payload. Slots fill in ascending strip order. Slots that receive nothing read as invalid and all-zero.

The search runs as a two-stage pipeline, and each stage advances only on the period strobe. In the first stage, four independent 32-strip groups each pack their own first eight hits. Each group uses a running saturating occupancy count to steer a hit onto a slot, and strips without a hit are skipped. In the second stage, the four short lists are merged in group order. The merge uses saturating offsets, so anything past the eighth hit overall is dropped. An overflow flag reports that more than eight strips fired. Every stage rewrites all of its slots on every strobe, so a previous period can never leave ghost entries behind.

Top module: `first_hits_collector`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe, every slot is zero, every slot valid bit is low and the overflow flag is low.
- R2: Valid slots hold the hit strips in strictly ascending strip index, and slot 0 holds the lowest hit strip.
- R3: Slot s occupies bits [13*s+12 : 13*s] of `slot_o`. Within a slot, bits [12:6] are the 7-bit strip index and bits [5:0] are that strip's payload, which is taken from `pay_i[6*i+5 : 6*i]` for strip i.
- R4: Slots beyond the number of kept hits have their valid bit low and read all-zero. This includes the case where the slot held data in the previous result.
- R5: When more than eight strips fire in a period, the overflow flag is high, all eight slots are valid, and only the eight lowest-indexed hit strips appear.
- R6: With exactly eight hits, all eight slots are valid and the overflow flag is low.
- R7: The inputs are sampled on the clock edge where the strobe is high. Their result appears on the outputs after the next strobe edge, and the outputs hold steady on edges without a strobe.
- R8: Back-to-back periods are handled at one result per strobe, and each result depends only on its own period's inputs.
- R9: Hits spread across the 32-strip groups merge in global strip order. This holds across group boundaries and when an earlier group already fills some or all slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Period strobe; advances both pipeline stages |
| hit_i | input | 128 | Hit flag per strip, bit i is strip i |
| pay_i | input | 768 | 6-bit payload per strip, strip i at bits [6*i+5:6*i] |
| slot_o | output | 104 | Eight 13-bit slots: strip index in the upper 7 bits, payload in the lower 6 |
| slot_valid_o | output | 8 | Valid bit per slot |
| overflow_o | output | 1 | More than eight strips fired in the period |

## Verification
An empty period and a sparse period in a single group exercise skipping and slot packing. A period of exactly eight hits is set against one with nine or more to separate the full case from the overflow case. An all-hit period and a period with only the last eight strips firing stress saturation and a late first hit. Patterns that straddle group boundaries, or that overfill group 0 while later groups also fire, show whether the merge offsets carry across groups. Back-to-back periods, followed by idle cycles with no strobe, expose latency, hold and leftover-data errors.

// File: rtl/hitsel_pkg.sv
package hitsel_pkg;

  // Saturating add used for slot ranks and merge offsets.
  function automatic int sat_add(input int a, input int b, input int lim);
    int s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

  // A valid vector is packed when it is of the form 0..01..1.
  function automatic bit is_packed(input logic [31:0] v);
    return ((v & (v + 32'd1)) == 32'd0);
  endfunction

endpackage

// File: rtl/strip_group_pack.sv
module strip_group_pack
  import hitsel_pkg::*;
#(
  parameter int GROUP  = 32,
  parameter int SLOTS  = 8,
  parameter int PAY_W  = 6,
  parameter int ADDR_W = 7,
  parameter int BASE   = 0,
  localparam int SLOT_W = ADDR_W + PAY_W,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int RAW_W  = $clog2(GROUP + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      strobe_i,
  input  logic [GROUP-1:0]          hit_i,
  input  logic [GROUP*PAY_W-1:0]    pay_i,
  output logic [SLOTS*SLOT_W-1:0]   slot_o,
  output logic [CNT_W-1:0]          cnt_o,
  output logic [RAW_W-1:0]          raw_o
);

  logic [CNT_W-1:0]        rank [GROUP];
  logic [CNT_W-1:0]        cnt_d;
  logic [RAW_W-1:0]        raw_d;
  logic [SLOTS*SLOT_W-1:0] slot_d;

  // Skip-and-add: each strip's rank is the saturating count of hits below it.
  always_comb begin
    int run;
    run   = 0;
    raw_d = '0;
    for (int j = 0; j < GROUP; j++) begin
      rank[j] = CNT_W'(run);
      if (hit_i[j]) begin
        run   = sat_add(run, 1, SLOTS);
        raw_d = raw_d + RAW_W'(1);
      end
    end
    cnt_d = CNT_W'(run);
  end

  // Steer each hit onto the slot equal to its rank; saturated ranks match no slot.
  always_comb begin
    slot_d = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int j = 0; j < GROUP; j++) begin
        if (hit_i[j] && (int'(rank[j]) == s)) begin
          slot_d[s*SLOT_W +: SLOT_W] = {ADDR_W'(BASE + j), pay_i[j*PAY_W +: PAY_W]};
        end
      end
    end
  end

  // Full rewrite on every strobe clears stale slots.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_o <= '0;
      cnt_o  <= '0;
      raw_o  <= '0;
    end else if (strobe_i) begin
      slot_o <= slot_d;
      cnt_o  <= cnt_d;
      raw_o  <= raw_d;
    end
  end

  // R5: the kept count never exceeds the fired count and equals it below saturation.
  p_group_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_o) <= int'(raw_o)) &&
    ((int'(cnt_o) < SLOTS) -> (int'(cnt_o) == int'(raw_o))));

endmodule

// File: rtl/group_merge.sv
module group_merge
  import hitsel_pkg::*;
#(
  parameter int NGRP   = 4,
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 13,
  parameter int CNT_W  = 4,
  parameter int RAW_W  = 6,
  parameter int TOT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          strobe_i,
  input  logic [NGRP*SLOTS*SLOT_W-1:0]  grp_slot_i,
  input  logic [NGRP*CNT_W-1:0]         grp_cnt_i,
  input  logic [NGRP*RAW_W-1:0]         grp_raw_i,
  output logic [SLOTS*SLOT_W-1:0]       slot_o,
  output logic [SLOTS-1:0]              valid_o,
  output logic                          overflow_o
);

  int                      offs [NGRP];
  int                      cnts [NGRP];
  logic [TOT_W-1:0]        total;
  logic [SLOTS*SLOT_W-1:0] slot_d;
  logic [SLOTS-1:0]        valid_d;

  // Saturating group offsets and the raw total across groups.
  always_comb begin
    int o;
    o     = 0;
    total = '0;
    for (int g = 0; g < NGRP; g++) begin
      cnts[g] = int'(grp_cnt_i[g*CNT_W +: CNT_W]);
      offs[g] = o;
      o       = sat_add(o, cnts[g], SLOTS);
      total   = total + TOT_W'(grp_raw_i[g*RAW_W +: RAW_W]);
    end
  end

  // Output slot s takes local entry k of group g when offs[g]+k == s.
  always_comb begin
    slot_d  = '0;
    valid_d = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int g = 0; g < NGRP; g++) begin
        for (int k = 0; k < SLOTS; k++) begin
          if ((k < cnts[g]) && (offs[g] + k == s)) begin
            slot_d[s*SLOT_W +: SLOT_W] = grp_slot_i[(g*SLOTS + k)*SLOT_W +: SLOT_W];
            valid_d[s] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_o     <= '0;
      valid_o    <= '0;
      overflow_o <= 1'b0;
    end else if (strobe_i) begin
      slot_o     <= slot_d;
      valid_o    <= valid_d;
      overflow_o <= (int'(total) > SLOTS);
    end
  end

  // R9: the merged valid count equals the saturated sum of group counts.
  p_merge_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> ($countones(valid_o) ==
                  sat_add(sat_add($past(cnts[0]), $past(cnts[1]), SLOTS),
                          sat_add($past(cnts[2]), $past(cnts[3]), SLOTS), SLOTS)));

endmodule

// File: rtl/first_hits_collector.sv
module first_hits_collector
  import hitsel_pkg::*;
#(
  parameter int NSTRIP = 128,
  parameter int GROUP  = 32,
  parameter int SLOTS  = 8,
  parameter int PAY_W  = 6,
  localparam int NGRP   = NSTRIP / GROUP,
  localparam int ADDR_W = $clog2(NSTRIP),
  localparam int SLOT_W = ADDR_W + PAY_W,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int RAW_W  = $clog2(GROUP + 1),
  localparam int TOT_W  = $clog2(NSTRIP + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      strobe_i,
  input  logic [NSTRIP-1:0]         hit_i,
  input  logic [NSTRIP*PAY_W-1:0]   pay_i,
  output logic [SLOTS*SLOT_W-1:0]   slot_o,
  output logic [SLOTS-1:0]          slot_valid_o,
  output logic                      overflow_o
);

  logic [NGRP*SLOTS*SLOT_W-1:0] grp_slot;
  logic [NGRP*CNT_W-1:0]        grp_cnt;
  logic [NGRP*RAW_W-1:0]        grp_raw;
  logic [TOT_W-1:0]             s1_total;   // hits captured by stage 1

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    strip_group_pack #(
      .GROUP (GROUP),
      .SLOTS (SLOTS),
      .PAY_W (PAY_W),
      .ADDR_W(ADDR_W),
      .BASE  (g * GROUP)
    ) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe_i(strobe_i),
      .hit_i   (hit_i[g*GROUP +: GROUP]),
      .pay_i   (pay_i[g*GROUP*PAY_W +: GROUP*PAY_W]),
      .slot_o  (grp_slot[g*SLOTS*SLOT_W +: SLOTS*SLOT_W]),
      .cnt_o   (grp_cnt[g*CNT_W +: CNT_W]),
      .raw_o   (grp_raw[g*RAW_W +: RAW_W])
    );
  end

  always_comb begin
    s1_total = '0;
    for (int g = 0; g < NGRP; g++) s1_total = s1_total + TOT_W'(grp_raw[g*RAW_W +: RAW_W]);
  end

  group_merge #(
    .NGRP  (NGRP),
    .SLOTS (SLOTS),
    .SLOT_W(SLOT_W),
    .CNT_W (CNT_W),
    .RAW_W (RAW_W),
    .TOT_W (TOT_W)
  ) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_i  (strobe_i),
    .grp_slot_i(grp_slot),
    .grp_cnt_i (grp_cnt),
    .grp_raw_i (grp_raw),
    .slot_o    (slot_o),
    .valid_o   (slot_valid_o),
    .overflow_o(overflow_o)
  );

  // R4: valid bits are packed from slot 0 upward.
  p_packed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_packed(32'(slot_valid_o)));

  // R5: overflow implies every slot is filled.
  p_ovf_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (&slot_valid_o));

  // R5: overflow follows the stage-1 hit total.
  p_ovf_total_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> (overflow_o == (int'($past(s1_total)) > SLOTS)));

  // R7: outputs hold on edges without a strobe.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> ($stable(slot_o) && $stable(slot_valid_o) && $stable(overflow_o)));

  for (genvar s = 0; s < SLOTS; s++) begin : g_chk
    // R4: invalid slots read zero.
    p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_valid_o[s] |-> (slot_o[s*SLOT_W +: SLOT_W] == '0));
    if (s > 0) begin : g_ord
      // R2: strip indices strictly ascend across valid slots.
      p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid_o[s] |->
          (slot_o[s*SLOT_W + PAY_W +: ADDR_W] > slot_o[(s-1)*SLOT_W + PAY_W +: ADDR_W]));
    end
  end

endmodule

// File: tb/tb_first_hits_collector.sv
module tb_first_hits_collector;

  localparam int N = 128, S = 8, PW = 6, SW = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            strobe = 1'b0;
  logic [N-1:0]    hits = '0;
  logic [N*PW-1:0] pays = '0;
  logic [S*SW-1:0] slot_o;
  logic [S-1:0]    valid_o;
  logic            ovf_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  first_hits_collector dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .hit_i(hits), .pay_i(pays),
    .slot_o(slot_o), .slot_valid_o(valid_o), .overflow_o(ovf_o)
  );

  // Software model: walk the strips upward, keep the first S hits.
  task automatic model(input logic [N-1:0] h, input logic [N*PW-1:0] p,
                       output logic [S*SW-1:0] es, output logic [S-1:0] ev, output logic eo);
    int n;
    n = 0; es = '0; ev = '0;
    for (int i = 0; i < N; i++) begin
      if (h[i]) begin
        if (n < S) begin
          es[n*SW +: SW] = {7'(i), p[i*PW +: PW]};
          ev[n] = 1'b1;
        end
        n++;
      end
    end
    eo = (n > S);
  endtask

  function automatic logic [N*PW-1:0] gen_pay(input int seed);
    logic [N*PW-1:0] p;
    for (int i = 0; i < N; i++) p[i*PW +: PW] = 6'((i * 37 + seed * 11 + 5) ^ (i >> 2));
    return p;
  endfunction

  task automatic compare(input string req, input logic [S*SW-1:0] es,
                         input logic [S-1:0] ev, input logic eo);
    for (int s = 0; s < S; s++) begin
      checks++;
      if (slot_o[s*SW +: SW] !== es[s*SW +: SW]) begin
        errors++;
        $display("FAIL %s slot %0d actual %h expected %h", req, s, slot_o[s*SW +: SW], es[s*SW +: SW]);
      end
    end
    checks++;
    if (valid_o !== ev) begin
      errors++;
      $display("FAIL %s valid actual %b expected %b", req, valid_o, ev);
    end
    checks++;
    if (ovf_o !== eo) begin
      errors++;
      $display("FAIL %s overflow actual %b expected %b", req, ovf_o, eo);
    end
  endtask

  // One strobe, inputs set at a falling edge; returns at the next falling edge.
  task automatic period(input logic [N-1:0] h, input logic [N*PW-1:0] p);
    @(negedge clk);
    hits = h; pays = p; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0; hits = '0; pays = '0;
  endtask

  task automatic run_single(input string req, input logic [N-1:0] h, input int seed);
    logic [S*SW-1:0] es; logic [S-1:0] ev; logic eo;
    logic [N*PW-1:0] p;
    p = gen_pay(seed);
    model(h, p, es, ev, eo);
    period(h, p);
    period('0, '0);
    compare(req, es, ev, eo);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    compare("R1 in reset", '0, '0, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare("R1 after release", '0, '0, 1'b0);
  endtask

  task automatic t_sparse();
    logic [N-1:0] h = '0;
    h[3] = 1; h[9] = 1; h[20] = 1;
    run_single("R3 sparse group0", h, 1);
  endtask

  task automatic t_empty_after_full();
    run_single("R5 all strips", {N{1'b1}}, 2);
    run_single("R4 empty after full", '0, 3);
  endtask

  task automatic t_exact_eight();
    logic [N-1:0] h = '0;
    for (int i = 0; i < 8; i++) h[i*15 + 2] = 1;
    run_single("R6 exactly eight", h, 4);
    h[127] = 1;
    run_single("R5 nine hits", h, 5);
  endtask

  task automatic t_last_eight();
    logic [N-1:0] h = '0;
    for (int i = 120; i < 128; i++) h[i] = 1;
    run_single("R2 last eight strips", h, 6);
  endtask

  task automatic t_boundaries();
    logic [N-1:0] h = '0;
    h[31] = 1; h[32] = 1; h[63] = 1; h[64] = 1; h[95] = 1; h[96] = 1;
    run_single("R9 group boundaries", h, 7);
    h = '0;
    for (int i = 0; i < 10; i++) h[i*3] = 1;
    h[40] = 1; h[100] = 1;
    run_single("R9 group0 overfull", h, 8);
    h = '0;
    h[5] = 1; h[6] = 1; h[33] = 1; h[70] = 1; h[71] = 1; h[72] = 1; h[110] = 1; h[111] = 1; h[126] = 1;
    run_single("R9 spread nine", h, 9);
  endtask

  task automatic t_pipeline();
    logic [N-1:0] ha = '0, hb = '0;
    logic [S*SW-1:0] ea, eb; logic [S-1:0] va, vb; logic oa, ob;
    logic [N*PW-1:0] pa, pb;
    for (int i = 0; i < 12; i++) ha[i*10 + 1] = 1;
    hb[50] = 1; hb[51] = 1;
    pa = gen_pay(10); pb = gen_pay(11);
    model(ha, pa, ea, va, oa);
    model(hb, pb, eb, vb, ob);
    period(ha, pa);
    compare("R7 latency before second strobe", '0, '0, 1'b0);
    period(hb, pb);
    compare("R8 back-to-back first", ea, va, oa);
    repeat (4) @(negedge clk);
    compare("R7 hold without strobe", ea, va, oa);
    period('0, '0);
    compare("R8 back-to-back second", eb, vb, ob);
    period('0, '0);
    compare("R4 flush", '0, '0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sparse();
    t_empty_after_full();
    t_exact_eight();
    t_last_eight();
    t_boundaries();
    t_pipeline();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule